// File: doc/BRIEF.md
# Pipelined Byte-Masked Memory Slave

This block is a word-addressed on-chip memory sitting behind a single-cycle pipelined request/reply interface. A client presents a request (read or write, word address, write data and a per-byte keep mask). The request is taken in any cycle where the client's request line and the memory's ready line are both high. Writes update the addressed word at the accepting clock edge. Only the bytes whose keep bit is low are changed.

Reads return on a separate reply channel. It has a one-cycle strobe and a data bus, and the client cannot stall it. Each reply arrives a fixed number of cycles after its request was taken. The read path is a shift pipeline, so a stream of back-to-back reads returns one word per cycle, in issue order.

An optional busy mode holds ready low for the single cycle after every accepted write. This models a controller that is briefly occupied. Ready never looks at the request of the same cycle.

Top module: `memslv_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `mem_rdy` is high and `rep_stb` is low.
- R2: On an accepted write, byte lane i (bits 8i+7..8i) of the addressed word takes the matching lane of `mem_wdata` when `mem_wkeep[i]` is 0. When `mem_wkeep[i]` is 1, that lane keeps its stored value.
- R3: A request is accepted only in a cycle where `mem_req` and `mem_rdy` are both high. A request made while `mem_rdy` is low changes no stored word and produces no reply.
- R4: With `BUSY_AFTER_WR` set to 1, `mem_rdy` is low for exactly the one cycle after each accepted write and high otherwise. With it set to 0, `mem_rdy` stays high. `mem_rdy` never depends on `mem_req` in the same cycle.
- R5: Every accepted read produces exactly one reply. `rep_stb` is high for one cycle, exactly `RD_LAT` cycles after the accepting cycle (`RD_LAT` >= 1). `rep_stb` is never high without an accepted read.
- R6: Replies return in the order the reads were accepted. Consecutive reads in consecutive cycles give replies in consecutive cycles.
- R7: A read accepted in any cycle after an accepted write to the same address returns the updated word.
- R8: `mem_wdata` and `mem_wkeep` have no effect on an accepted read or on the stored contents during a read.
- R9: In a cycle where `mem_req` is low, the values on `mem_write`, `mem_addr`, `mem_wdata` and `mem_wkeep` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdy | output | 1 | Memory can take a request this cycle |
| mem_req | input | 1 | Request valid |
| mem_write | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | DATA_W | Write data |
| mem_wkeep | input | DATA_W/8 | Per-byte keep mask, 0 = write that byte |
| rep_stb | output | 1 | Read reply valid for one cycle |
| rep_data | output | DATA_W | Read reply data, valid only with `rep_stb` |

## Verification
The bench writes and reads every word of a small memory. It sweeps every keep-mask value on every address, so a lane-select or mask-polarity error corrupts a byte that the next read exposes. It issues a request in each busy cycle right after a write. A design that took such a request anyway would change the word or return an extra reply, and the shadow model flags either one. Long runs of back-to-back reads check both the exact reply cycle and the order, which catches an off-by-one in the latency pipeline or a dropped stage. Reads carrying junk write data and idle cycles carrying junk fields confirm that neither can alter the stored contents.

// File: rtl/memslv_pkg.sv
package memslv_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } mem_op_e;

  localparam int unsigned LANE_W = 8;

  function automatic int unsigned lane_count(input int unsigned data_w);
    return data_w / LANE_W;
  endfunction

endpackage

// File: rtl/memslv_ready_ctl.sv
module memslv_ready_ctl #(
  parameter bit BUSY_AFTER_WR = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_wr,
  output logic rdy
);

  logic busy_q;
  logic busy_d;

  // busy for one cycle after an accepted write, never from same-cycle req
  always_comb begin
    busy_d = 1'b0;
    if (BUSY_AFTER_WR && acc_wr) begin
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  assign rdy = ~busy_q;

endmodule

// File: rtl/memslv_array.sv
module memslv_array
  import memslv_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [DATA_W/8-1:0]   wr_keep,
  output logic [DATA_W-1:0]     rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q [DEPTH];
    logic              lane_we;

    // keep bit low means this byte is written
    assign lane_we = wr_en & ~wr_keep[l];

    always_ff @(posedge clk) begin
      if (lane_we) begin
        lane_q[addr] <= wr_data[l*LANE_W +: LANE_W];
      end
    end

    assign rd_data[l*LANE_W +: LANE_W] = lane_q[addr];
  end

endmodule

// File: rtl/memslv_rd_pipe.sv
module memslv_rd_pipe #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);

  localparam int unsigned LAST = RD_LAT - 1;

  logic              vld_q  [RD_LAT];
  logic              vld_d  [RD_LAT];
  logic [DATA_W-1:0] data_q [RD_LAT];
  logic [DATA_W-1:0] data_d [RD_LAT];
  logic              ld_en  [RD_LAT];

  for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_comb begin
        vld_d[s]  = in_vld;
        data_d[s] = in_data;
        ld_en[s]  = in_vld;
      end
    end else begin : g_body
      always_comb begin
        vld_d[s]  = vld_q[s-1];
        data_d[s] = data_q[s-1];
        ld_en[s]  = vld_q[s-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
      end else begin
        vld_q[s] <= vld_d[s];
      end
    end

    // data carries no reset; it is qualified by the valid bit
    always_ff @(posedge clk) begin
      if (ld_en[s]) begin
        data_q[s] <= data_d[s];
      end
    end
  end

  assign out_vld  = vld_q[LAST];
  assign out_data = data_q[LAST];

endmodule

// File: rtl/memslv_top.sv
module memslv_top
  import memslv_pkg::*;
#(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned RD_LAT        = 2,
  parameter bit          BUSY_AFTER_WR = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                mem_rdy,
  input  logic                mem_req,
  input  logic                mem_write,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W/8-1:0] mem_wkeep,
  output logic                rep_stb,
  output logic [DATA_W-1:0]   rep_data
);

  mem_op_e           op;
  logic              acc;
  logic              acc_wr;
  logic              acc_rd;
  logic [DATA_W-1:0] arr_rdata;

  always_comb begin
    op     = mem_op_e'(mem_write);
    acc    = mem_req & mem_rdy;
    acc_wr = acc & (op == OP_WRITE);
    acc_rd = acc & (op == OP_READ);
  end

  memslv_ready_ctl #(
    .BUSY_AFTER_WR (BUSY_AFTER_WR)
  ) u_rdy (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_wr (acc_wr),
    .rdy    (mem_rdy)
  );

  memslv_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_arr (
    .clk     (clk),
    .wr_en   (acc_wr),
    .addr    (mem_addr),
    .wr_data (mem_wdata),
    .wr_keep (mem_wkeep),
    .rd_data (arr_rdata)
  );

  memslv_rd_pipe #(
    .DATA_W (DATA_W),
    .RD_LAT (RD_LAT)
  ) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (acc_rd),
    .in_data  (arr_rdata),
    .out_vld  (rep_stb),
    .out_data (rep_data)
  );

endmodule

// File: rtl/memslv_chk.sv
module memslv_chk #(
  parameter int unsigned RD_LAT        = 2,
  parameter bit          BUSY_AFTER_WR = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic mem_rdy,
  input logic mem_req,
  input logic mem_write,
  input logic rep_stb
);

  localparam int unsigned CNT_W = $clog2(RD_LAT + 2) + 1;

  logic [CNT_W-1:0] outst_q;
  logic             rd_acc;

  assign rd_acc = mem_req & mem_rdy & ~mem_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= '0;
    end else begin
      outst_q <= outst_q + CNT_W'(rd_acc) - CNT_W'(rep_stb);
    end
  end

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (BUSY_AFTER_WR && mem_req && mem_rdy && mem_write) |=> !mem_rdy); // R4

  AST_RDY_LOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rdy |=> mem_rdy); // R4

  AST_RDY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rdy) |-> $past(mem_req && mem_write)); // R4

  AST_STROBE_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rep_stb |-> (outst_q != '0)); // R5

  AST_OUTSTANDING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(outst_q) <= int'(RD_LAT)); // R6

endmodule

bind memslv_top memslv_chk #(
  .RD_LAT        (RD_LAT),
  .BUSY_AFTER_WR (BUSY_AFTER_WR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rdy   (mem_rdy),
  .mem_req   (mem_req),
  .mem_write (mem_write),
  .rep_stb   (rep_stb)
);

// File: tb/memslv_top_tb_top.sv
`timescale 1ns/1ps
module memslv_top_tb_top;

  localparam int AW  = 4;
  localparam int DW  = 16;
  localparam int LAT = 2;
  localparam int NL  = DW / 8;
  localparam int QN  = 64;

  logic          clk;
  logic          rst_n;
  logic          mem_rdy;
  logic          mem_req;
  logic          mem_write;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [NL-1:0] mem_wkeep;
  logic          rep_stb;
  logic [DW-1:0] rep_data;

  int total;
  int bad;
  int cyc;
  bit running;
  bit done;
  bit exp_rdy;

  logic [DW-1:0] shadow [1<<AW];
  logic [DW-1:0] q_data [QN];
  int            q_due  [QN];
  int            q_head;
  int            q_tail;

  memslv_top #(
    .ADDR_W (AW), .DATA_W (DW), .RD_LAT (LAT), .BUSY_AFTER_WR (1'b1)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .mem_rdy (mem_rdy), .mem_req (mem_req),
    .mem_write (mem_write), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .mem_wkeep (mem_wkeep), .rep_stb (rep_stb), .rep_data (rep_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string rq, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", rq, act, expv, cyc);
    end
  endtask

  // reply monitor: timing (R5), order and data (R6)
  always @(negedge clk) begin
    if (running && rst_n) begin
      if (rep_stb) begin
        if (q_head == q_tail) begin
          check(1'b0, "R3 reply without accepted read", 16'(rep_stb), 16'h0);
        end else begin
          check(q_due[q_head % QN] == cyc, "R5 reply cycle",
                DW'(cyc), DW'(q_due[q_head % QN]));
          check(rep_data == q_data[q_head % QN], "R6 R2 R7 reply data",
                rep_data, q_data[q_head % QN]);
          q_head++;
        end
      end else if (q_head != q_tail && q_due[q_head % QN] <= cyc) begin
        check(1'b0, "R5 missing reply", 16'h0, 16'h1);
        q_head++;
      end
    end
  end

  // one cycle of stimulus; model follows the requirements
  task automatic issue(input bit rq, input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [NL-1:0] k);
    bit acc;
    @(negedge clk);
    mem_req = rq; mem_write = wr; mem_addr = a; mem_wdata = d; mem_wkeep = k;
    #0.5;
    check(mem_rdy == exp_rdy, "R4 ready level", DW'(mem_rdy), DW'(exp_rdy));
    acc = rq && mem_rdy;
    if (acc && wr) begin
      for (int l = 0; l < NL; l++)
        if (!k[l]) shadow[a][l*8 +: 8] = d[l*8 +: 8];
    end else if (acc) begin
      q_data[q_tail % QN] = shadow[a];
      q_due[q_tail % QN]  = cyc + LAT;
      q_tail++;
    end
    exp_rdy = !(acc && wr);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(1'b0, 1'b0, '0, '0, '0);
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0; running = 0; done = 0; exp_rdy = 1;
    q_head = 0; q_tail = 0;
    mem_req = 0; mem_write = 0; mem_addr = '0; mem_wdata = '0; mem_wkeep = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    check(mem_rdy == 1'b1, "R1 ready in reset", DW'(mem_rdy), 16'h1);
    check(rep_stb == 1'b0, "R1 strobe in reset", DW'(rep_stb), 16'h0);
    rst_n = 1'b1;
    running = 1;
    @(negedge clk);
    check(mem_rdy == 1'b1 && rep_stb == 1'b0, "R1 after release",
          DW'({mem_rdy, rep_stb}), 16'h2);

    // fill every word with full writes (keep=0), then stream reads (R6)
    for (int a = 0; a < (1<<AW); a++) begin
      issue(1'b1, 1'b1, AW'(a), DW'(a * 16'h1111) ^ 16'h5A3C, '0);
      idle(1);
    end
    for (int a = 0; a < (1<<AW); a++) issue(1'b1, 1'b0, AW'(a), 16'hFFFF, '1);
    idle(LAT + 1);

    // every keep value on every address (R2), request in busy cycle (R3),
    // then read of the new data (R7)
    for (int a = 0; a < (1<<AW); a++) begin
      for (int k = 0; k < (1<<NL); k++) begin
        issue(1'b1, 1'b1, AW'(a), DW'(a * 16'h0F1 + k * 16'h3303 + 16'h0101), NL'(k));
        issue(1'b1, k[0], AW'(a), 16'hDEAD, '0);   // dropped: ready low (R3)
        issue(1'b1, 1'b0, AW'(a), '0, '0);
      end
    end
    idle(LAT + 1);

    // R8: reads carrying junk write fields leave contents unchanged
    for (int a = 0; a < (1<<AW); a++) issue(1'b1, 1'b0, AW'(a), ~DW'(a), '0);
    for (int a = 0; a < (1<<AW); a++) issue(1'b1, 1'b0, AW'(a), '0, '1);

    // R9: idle cycles with junk write fields, then read back
    for (int a = 0; a < (1<<AW); a++) issue(1'b0, 1'b1, AW'(a), 16'hBEEF, '0);
    for (int a = 0; a < (1<<AW); a++) issue(1'b1, 1'b0, AW'(a), '0, '0);

    // R7: write then read at the first ready cycle, alternating
    for (int a = 0; a < (1<<AW); a++) begin
      issue(1'b1, 1'b1, AW'(a), DW'(16'hC000 | a), '0);
      idle(1);
      issue(1'b1, 1'b0, AW'(a), '0, '0);
    end
    idle(LAT + 2);
    check(q_head == q_tail, "R5 all replies returned", DW'(q_tail - q_head), 16'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule